// File: doc/BRIEF.md
# Interrupt Coalescing Event Timer

This block cuts the interrupt rate of a network data path. Each receive or transmit completion that belongs to the moderated group reaches the block as one already-qualified single-cycle pulse. The block gives a single active-low level interrupt. The interrupt asserts when a programmed number of such events has built up. It also asserts when a programmed delay, counted from the first event after arming, has run out. Whichever condition comes first wins. A prescaler divides the system clock into a 10 microsecond tick, and the delay is counted in those ticks.

The block is controlled by four states. In `ST_IDLE` the block is disabled. In `ST_ARMED` the counter and timer are loaded and the timer is stopped. In `ST_TIMING` the timer counts down on each tick. In `ST_FIRED` the interrupt is asserted. The transitions are:

- `ST_IDLE`→`ST_ARMED` when the block is enabled. This transition loads the count and the delay.
- `ST_ARMED`→`ST_TIMING` on the first event, unless that event already exhausts the count.
- `ST_ARMED`→`ST_FIRED` on an event that exhausts the count.
- `ST_TIMING`→`ST_FIRED` when the count or the delay is exhausted.
- `ST_FIRED`→`ST_ARMED` on an acknowledge. This transition reloads the count and the delay.
- Any state→`ST_IDLE` when the enable is low.

Software sets the two thresholds and raises the enable. After servicing the interrupt, software pulses the acknowledge to re-arm the block.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `irq_n` is 1 (deasserted) and the block is idle.
- R2: While enabled and armed with no events, the timer stays stopped and `irq_n` stays 1 however long the block waits.
- R3: Each cycle with `event_i` high decrements the event count by exactly one. With `cfg_count`=N, `irq_n` goes to 0 right after the clock edge that samples the N-th event.
- R4: The first event after arming starts the timer. Later events neither restart it nor reload it.
- R5: The timer decrements once per tick, and ticks are PRESCALE clocks apart. The prescaler starts from zero when the timer starts. If the count is not exhausted first, `irq_n` goes to 0 exactly PRESCALE*`cfg_delay` clock edges after the edge that sampled the first event.
- R6: With `cfg_count`=1, the first event drives `irq_n` to 0 right after the edge that samples it.
- R7: Once asserted, `irq_n` stays 0 until `ack_i`. Events that arrive while it is asserted are ignored, and they do not count toward the next interval.
- R8: `ack_i` while the interrupt is asserted deasserts `irq_n` at the next edge. It also reloads both the count and the delay and leaves the timer stopped until the next event.
- R9: If the count and the timer are exhausted on the same edge, there is a single assertion, and one `ack_i` clears it.
- R10: `enable` low sends the block to idle and `irq_n` to 1 at the next edge. Events arriving while the block is disabled are ignored. Raising `enable` again reloads both thresholds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Moderation enable; low forces idle |
| cfg_count | input | CNT_W | Event-count threshold, nonzero |
| cfg_delay | input | TMR_W | Delay threshold in ticks, nonzero |
| event_i | input | 1 | One-cycle pulse per qualifying event |
| ack_i | input | 1 | Acknowledge / re-arm pulse |
| irq_n | output | 1 | Interrupt, active low, level |

## Verification
A counter that is off by one shows up at `irq_n` one event early or late. The check therefore samples the cycle right after each expected terminal event, and also the cycle before it. A timer that restarts on later events, or a prescaler that does not restart from zero, moves the assertion by whole ticks, so the bench compares against the exact PRESCALE*delay edge. A state machine stuck in the asserted state, or one that does not reload, shows up after an acknowledge. In that case the interrupt either stays low or fires on the wrong event number, and this appears within one event of the re-arm.

// File: rtl/irq_coalesce_pkg.sv
package irq_coalesce_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_TIMING = 2'd2,
        ST_FIRED  = 2'd3
    } coal_state_t;
endpackage

// File: rtl/irq_down_counter.sv
module irq_down_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         at_one
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load) begin
            val_q <= load_val;
        end else if (dec) begin
            val_q <= val_q - W'(1);
        end
    end

    assign at_one = (val_q == W'(1));

    // R3
    cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (val_q != '0));
endmodule

// File: rtl/irq_tick_gen.sv
module irq_tick_gen #(
    parameter int DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run || div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + PW'(1);
        end
    end

    assign tick = run && (div_q == LAST);

    // R5
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R5
    tick_fresh_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> !tick);
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irq_coalesce_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic event_i,
    input  logic ack_i,
    input  logic tick,
    input  logic cnt_one,
    input  logic tmr_one,
    output logic load,
    output logic cnt_dec,
    output logic tmr_dec,
    output logic run,
    output logic irq_n
);
    coal_state_t state_q, state_d;
    logic        fire;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        load    = 1'b0;
        cnt_dec = 1'b0;
        tmr_dec = 1'b0;
        run     = 1'b0;
        irq_n   = 1'b1;
        unique case (state_q)
            ST_IDLE:   load = enable;
            ST_ARMED:  cnt_dec = enable && event_i;
            ST_TIMING: begin
                run     = 1'b1;
                cnt_dec = enable && event_i;
                tmr_dec = enable && tick;
            end
            ST_FIRED: begin
                irq_n = 1'b0;
                load  = enable && ack_i;
            end
        endcase
        fire = (cnt_dec && cnt_one) || (tmr_dec && tmr_one);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (enable) state_d = ST_ARMED;
            ST_ARMED: begin
                if (!enable)      state_d = ST_IDLE;
                else if (fire)    state_d = ST_FIRED;
                else if (cnt_dec) state_d = ST_TIMING;
            end
            ST_TIMING: begin
                if (!enable)   state_d = ST_IDLE;
                else if (fire) state_d = ST_FIRED;
            end
            ST_FIRED: begin
                if (!enable)    state_d = ST_IDLE;
                else if (ack_i) state_d = ST_ARMED;
            end
        endcase
    end

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && enable && !ack_i) |=> !irq_n);

    // R8
    ack_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && enable && ack_i) |=> (irq_n && state_q == ST_ARMED));

    // R10
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (irq_n && state_q == ST_IDLE));

    // R6
    single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && enable && event_i && cnt_one) |=> !irq_n);

    // R2
    armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED && enable && !event_i) |=> (irq_n && !tick));
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce #(
    parameter int CNT_W    = 8,
    parameter int TMR_W    = 8,
    parameter int PRESCALE = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [TMR_W-1:0] cfg_delay,
    input  logic             event_i,
    input  logic             ack_i,
    output logic             irq_n
);
    logic load, cnt_dec, tmr_dec, run, tick, cnt_one, tmr_one;

    irq_coalesce_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .event_i (event_i),
        .ack_i   (ack_i),
        .tick    (tick),
        .cnt_one (cnt_one),
        .tmr_one (tmr_one),
        .load    (load),
        .cnt_dec (cnt_dec),
        .tmr_dec (tmr_dec),
        .run     (run),
        .irq_n   (irq_n)
    );

    irq_tick_gen #(.DIV(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    irq_down_counter #(.W(CNT_W)) u_evt_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cfg_count),
        .dec      (cnt_dec),
        .at_one   (cnt_one)
    );

    irq_down_counter #(.W(TMR_W)) u_delay_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cfg_delay),
        .dec      (tmr_dec),
        .at_one   (tmr_one)
    );
endmodule

// File: tb/irq_coalesce_tb.sv
module irq_coalesce_tb;
    localparam int CW = 4;
    localparam int TW = 4;
    localparam int P  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] cfg_count = '0;
    logic [TW-1:0] cfg_delay = '0;
    logic          event_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          irq_n;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_coalesce #(.CNT_W(CW), .TMR_W(TW), .PRESCALE(P)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_count(cfg_count),
        .cfg_delay(cfg_delay), .event_i(event_i), .ack_i(ack_i), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic exp);
        checks++;
        if (irq_n !== exp) begin
            errors++;
            $display("FAIL %s: irq_n=%b expected %b at %0t", req, irq_n, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_event();
        event_i = 1'b1; @(negedge clk); event_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1; @(negedge clk); ack_i = 1'b0;
    endtask

    task automatic arm(input int c, input int d);
        enable = 1'b0; @(negedge clk);
        cfg_count = CW'(c); cfg_delay = TW'(d);
        enable = 1'b1; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 reset", 1'b1);
    endtask

    task automatic t_armed_quiet();
        arm(3, 1);
        idle(30);
        chk("R2 armed no events", 1'b1);
    endtask

    task automatic t_count_path();
        arm(3, 15);
        pulse_event(); idle(1);
        pulse_event(); idle(1);
        chk("R3 after 2 of 3 events", 1'b1);
        pulse_event();
        chk("R3 third event", 1'b0);
        idle(5);
        chk("R7 hold low", 1'b0);
        pulse_ack();
        chk("R8 ack release", 1'b1);
    endtask

    task automatic t_timer_path();
        arm(5, 3);
        pulse_event();
        for (int i = 1; i <= P * 3; i++) begin
            event_i = (i == 3 || i == 7);
            @(negedge clk);
            event_i = 1'b0;
            if (i == P * 3 - 1) chk("R4/R5 one edge before timeout", 1'b1);
            if (i == P * 3)     chk("R4/R5 timeout edge", 1'b0);
        end
        pulse_ack();
    endtask

    task automatic t_single();
        arm(1, 9);
        chk("R6 before event", 1'b1);
        pulse_event();
        chk("R6 count of one", 1'b0);
        pulse_ack();
    endtask

    task automatic t_ignore_fired();
        arm(2, 15);
        pulse_event(); pulse_event();
        chk("R7 fired", 1'b0);
        pulse_event(); pulse_event(); pulse_event();
        chk("R7 still low during events", 1'b0);
        pulse_ack();
        pulse_event();
        chk("R7 events while fired not counted", 1'b1);
        pulse_event();
        chk("R7 full count after rearm", 1'b0);
        pulse_ack();
    endtask

    task automatic t_rearm_idle();
        arm(1, 2);
        pulse_event();
        pulse_ack();
        idle(40);
        chk("R8 timer stopped after ack", 1'b1);
        pulse_event();
        chk("R8 count reloaded", 1'b0);
        pulse_ack();
    endtask

    task automatic t_simultaneous();
        arm(2, 2);
        pulse_event();
        idle(P * 2 - 1);
        chk("R9 before coincident edge", 1'b1);
        pulse_event();
        chk("R9 coincident fire", 1'b0);
        pulse_ack();
        chk("R9 single ack clears", 1'b1);
        idle(20);
        chk("R9 no second assertion", 1'b1);
    endtask

    task automatic t_disable();
        arm(4, 2);
        pulse_event();
        enable = 1'b0;
        idle(2);
        pulse_event(); pulse_event(); pulse_event(); pulse_event();
        idle(20);
        chk("R10 disabled no irq", 1'b1);
        enable = 1'b1; @(negedge clk);
        pulse_event(); pulse_event(); pulse_event();
        chk("R10 reload on enable", 1'b1);
        pulse_event();
        chk("R10 fires after reload", 1'b0);
        enable = 1'b0; @(negedge clk);
        chk("R10 disable clears irq", 1'b1);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_armed_quiet();
        t_count_path();
        t_timer_path();
        t_single();
        t_ignore_fired();
        t_rearm_idle();
        t_simultaneous();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 20000; i++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule